// File: doc/BRIEF.md
# Time-Shared Queue Status Bus Port

This block sits in each device of a chain and places that device's four almost-empty queue flags onto a status bus that all the devices share. Only one device may drive the bus at a time. The block has an output-enable for its drive. The bus value is forced to zero whenever that enable is low, so the bus can be built as an OR of the device outputs.

A strap is sampled while reset is held and picks one of two modes. In polled mode the devices form a ring. A token travels round the ring and moves one device per read-clock edge. The device that holds the token drives the bus for that cycle. It raises its sync and token-out outputs for the same cycle, and the next device in the ring takes the bus on the following edge. The device with identity 1 owns the token when reset ends. In direct mode the token path is unused. A device is chosen by presenting its address together with a strobe on a read-clock edge. Strobes are refused while configuration is still pending.

Top module: `flagbus_port`

Controller states:
- `ST_RESET`: entered while reset is held.
- `ST_DIR_IDLE`: direct mode, not selected.
- `ST_DIR_SEL`: direct mode, driving the bus.
- `ST_POLL_WAIT`: polled mode, without the token.
- `ST_POLL_SLOT`: polled mode, holding the token and driving the bus.

Transitions:
- `ST_RESET` goes to `ST_POLL_SLOT` in polled mode when the device is the token holder or `tok_in` is high. Otherwise it goes to `ST_POLL_WAIT`.
- In direct mode, `ST_RESET` goes to `ST_DIR_SEL` on an accepted matching strobe. Otherwise it goes to `ST_DIR_IDLE`.
- `ST_DIR_IDLE` goes to `ST_DIR_SEL` on an accepted strobe whose address matches.
- `ST_DIR_SEL` goes to `ST_DIR_IDLE` on an accepted strobe whose address does not match.
- `ST_POLL_WAIT` goes to `ST_POLL_SLOT` when `tok_in` is high.
- `ST_POLL_SLOT` stays in `ST_POLL_SLOT` when `tok_in` is high. Otherwise it goes to `ST_POLL_WAIT`.

## Requirements
- R1: `mode_strap` is captured on every clock edge while `rst` is high: 1 selects polled mode and 0 selects direct mode. Changes to the strap after reset have no effect.
- R2: While `rst` is high, `bus_oe`, `sync_out`, `tok_out` and `bus_out` are all 0.
- R3: In polled mode, the device with `DEV_ID` 1 drives the bus in the cycle after the first clock edge following reset release. All other devices wait for the token.
- R4: In polled mode, a device drives the bus in the cycle after any edge at which `tok_in` was high. It stops driving after an edge at which `tok_in` was low. In a ring of N devices, ownership therefore advances one device per cycle and wraps after N cycles.
- R5: In polled mode, `sync_out`, `tok_out` and `bus_oe` are high exactly in the cycles in which the device drives the bus.
- R6: While driving, `bus_out` equals the value of `flags_in` at the most recent clock edge. Bit i carries the almost-empty flag of queue i.
- R7: In direct mode, an edge with `sel_strobe` high, `prog_pending` low and `sel_addr` equal to `DEV_ID` selects the device from the next cycle. The device then drives until it is deselected.
- R8: In direct mode, an accepted strobe with a non-matching address deselects the device from the next cycle.
- R9: In direct mode, a strobe at an edge where `prog_pending` is high has no effect.
- R10: In direct mode, `tok_in` is ignored, and `tok_out` and `sync_out` stay 0.
- R11: In polled mode, `sel_strobe` and `sel_addr` have no effect.
- R12: While `bus_oe` is 0, `bus_out` is 0.
- R13: In a chain of devices, at most one device has `bus_oe` high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_strap | input | 1 | Mode strap: 1 for polled, 0 for direct |
| sel_strobe | input | 1 | Direct-mode select strobe |
| sel_addr | input | AW | Direct-mode device address |
| prog_pending | input | 1 | High while configuration is still pending |
| tok_in | input | 1 | Token from the previous device |
| tok_out | output | 1 | Token to the next device |
| sync_out | output | 1 | High during this device's polled slot |
| flags_in | input | FW | Almost-empty flags, one per queue |
| bus_out | output | FW | Status bus contribution |
| bus_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume that exactly one token circulates in a polled ring. They also assume that every device in a chain sees the same strap, and that each device has a distinct identity. The bench builds a ring of three devices that share one reset and one strap. It releases a single token through the device with identity 1.

The strap is moved after reset to probe R1. This is safe because the mode-hold property only constrains the latched mode. In direct mode the bench forces the token inputs high to exercise R10, which the block must tolerate. Direct-mode addresses are swept over every value of the address bus.

// File: rtl/flagbus_pkg.sv
package flagbus_pkg;

    typedef enum logic [2:0] {
        ST_RESET     = 3'd0,
        ST_DIR_IDLE  = 3'd1,
        ST_DIR_SEL   = 3'd2,
        ST_POLL_WAIT = 3'd3,
        ST_POLL_SLOT = 3'd4
    } fb_state_t;

    function automatic logic fb_drives(input fb_state_t s);
        return (s == ST_DIR_SEL) || (s == ST_POLL_SLOT);
    endfunction

endpackage

// File: rtl/flagbus_mode.sv
module flagbus_mode (
    input  logic clk,
    input  logic rst,
    input  logic mode_strap,
    output logic poll_mode
);

    // Strap follows the pin only while reset is held, frozen afterwards
    always_ff @(posedge clk) begin
        if (rst) poll_mode <= mode_strap;
    end

    // R1: latched mode never moves outside reset
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(poll_mode));

endmodule

// File: rtl/flagbus_fsm.sv
module flagbus_fsm
    import flagbus_pkg::*;
#(
    parameter int AW     = 3,
    parameter int DEV_ID = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          poll_mode,
    input  logic          strobe,
    input  logic          prog_pending,
    input  logic [AW-1:0] addr,
    input  logic          tok_in,
    output logic          drv_now,
    output logic          drv_next,
    output logic          slot_now
);

    localparam logic [AW-1:0] MY_ADDR = AW'(DEV_ID);
    localparam bit            HOLDER  = (DEV_ID == 1);

    fb_state_t state_q, state_n;
    logic      boot_tok;
    logic      sel_ok, hit;

    // Variant choice: only the ring head starts with the token
    generate
        if (HOLDER) begin : g_holder
            assign boot_tok = 1'b1;
        end else begin : g_follower
            assign boot_tok = 1'b0;
        end
    endgenerate

    assign sel_ok = strobe && !prog_pending;
    assign hit    = (addr == MY_ADDR);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RESET;
        else     state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RESET: begin
                if (poll_mode)
                    state_n = (boot_tok || tok_in) ? ST_POLL_SLOT : ST_POLL_WAIT;
                else
                    state_n = (sel_ok && hit) ? ST_DIR_SEL : ST_DIR_IDLE;
            end
            ST_DIR_IDLE:  if (sel_ok && hit)  state_n = ST_DIR_SEL;
            ST_DIR_SEL:   if (sel_ok && !hit) state_n = ST_DIR_IDLE;
            ST_POLL_WAIT: if (tok_in)         state_n = ST_POLL_SLOT;
            ST_POLL_SLOT: state_n = tok_in ? ST_POLL_SLOT : ST_POLL_WAIT;
            default:      state_n = ST_RESET;
        endcase
    end

    always_comb begin
        drv_now  = fb_drives(state_q);
        drv_next = fb_drives(state_n);
        slot_now = (state_q == ST_POLL_SLOT);
    end

    // R4: a token arrival opens the slot on the next cycle
    p_poll_enter_r4: assert property (@(posedge clk) disable iff (rst)
        (poll_mode && tok_in) |=> slot_now);

    // R4: without a fresh token the slot closes
    p_poll_leave_r4: assert property (@(posedge clk) disable iff (rst)
        (poll_mode && slot_now && !tok_in) |=> !slot_now);

    // R10: no slot ever opens in direct mode
    p_direct_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !poll_mode |-> !slot_now);

    // R9: strobes are refused while configuration is pending
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!poll_mode && prog_pending && !drv_now) |=> !drv_now);

    // R7: an accepted matching strobe selects the device
    p_select_r7: assert property (@(posedge clk) disable iff (rst)
        (!poll_mode && strobe && !prog_pending && addr == MY_ADDR) |=> drv_now);

endmodule

// File: rtl/flagbus_drive.sv
module flagbus_drive #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          oe_in,
    input  logic [FW-1:0] flags_in,
    output logic [FW-1:0] bus_out,
    output logic          bus_oe
);

    logic [FW-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst)       cap_q <= '0;
        else if (load) cap_q <= flags_in;
    end

    always_comb begin
        bus_oe  = oe_in;
        bus_out = oe_in ? cap_q : '0;
    end

    // R6: the bus shows the flags sampled at the loading edge
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> (bus_out == $past(flags_in)));

endmodule

// File: rtl/flagbus_port.sv
module flagbus_port #(
    parameter int AW     = 3,
    parameter int FW     = 4,
    parameter int DEV_ID = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_strap,
    input  logic          sel_strobe,
    input  logic [AW-1:0] sel_addr,
    input  logic          prog_pending,
    input  logic          tok_in,
    output logic          tok_out,
    output logic          sync_out,
    input  logic [FW-1:0] flags_in,
    output logic [FW-1:0] bus_out,
    output logic          bus_oe
);

    logic poll_mode;
    logic drv_now, drv_next, slot_now;

    flagbus_mode u_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_strap (mode_strap),
        .poll_mode  (poll_mode)
    );

    flagbus_fsm #(.AW(AW), .DEV_ID(DEV_ID)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .poll_mode    (poll_mode),
        .strobe       (sel_strobe),
        .prog_pending (prog_pending),
        .addr         (sel_addr),
        .tok_in       (tok_in),
        .drv_now      (drv_now),
        .drv_next     (drv_next),
        .slot_now     (slot_now)
    );

    flagbus_drive #(.FW(FW)) u_drive (
        .clk      (clk),
        .rst      (rst),
        .load     (drv_next),
        .oe_in    (drv_now),
        .flags_in (flags_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

    assign tok_out  = slot_now;
    assign sync_out = slot_now;

    // R12: an undriven port contributes nothing to the shared bus
    p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_out == '0));

    // R5: sync marks a cycle in which this device owns the bus
    p_sync_owns_r5: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> bus_oe);

endmodule

// File: tb/flagbus_port_tb.sv
module flagbus_port_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap = 1'b1;
    logic       stb = 1'b0;
    logic [2:0] addr = '0;
    logic       busy = 1'b0;
    logic       ring = 1'b1;
    logic [3:1] tforce = '0;
    logic [7:0] cnt = '0;

    logic [3:1] t_in, t_out, syn, oe;
    logic [3:0] b1, b2, b3, fl1, fl2, fl3, bus_or;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fl1 = 4'(cnt * 7 + 1);
    assign fl2 = 4'(cnt * 7 + 6);
    assign fl3 = 4'(cnt * 7 + 11);
    assign t_in = ring ? {t_out[2], t_out[1], t_out[3]} : tforce;
    assign bus_or = b1 | b2 | b3;

    flagbus_port #(.AW(3), .FW(4), .DEV_ID(1)) u_dut (
        .clk(clk), .rst(rst), .mode_strap(strap), .sel_strobe(stb), .sel_addr(addr),
        .prog_pending(busy), .tok_in(t_in[1]), .tok_out(t_out[1]), .sync_out(syn[1]),
        .flags_in(fl1), .bus_out(b1), .bus_oe(oe[1]));
    flagbus_port #(.AW(3), .FW(4), .DEV_ID(2)) u_dut2 (
        .clk(clk), .rst(rst), .mode_strap(strap), .sel_strobe(stb), .sel_addr(addr),
        .prog_pending(busy), .tok_in(t_in[2]), .tok_out(t_out[2]), .sync_out(syn[2]),
        .flags_in(fl2), .bus_out(b2), .bus_oe(oe[2]));
    flagbus_port #(.AW(3), .FW(4), .DEV_ID(3)) u_dut3 (
        .clk(clk), .rst(rst), .mode_strap(strap), .sel_strobe(stb), .sel_addr(addr),
        .prog_pending(busy), .tok_in(t_in[3]), .tok_out(t_out[3]), .sync_out(syn[3]),
        .flags_in(fl3), .bus_out(b3), .bus_oe(oe[3]));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] flag_of(input int k);
        return (k == 1) ? fl1 : (k == 2) ? fl2 : (k == 3) ? fl3 : 4'h0;
    endfunction

    task automatic check_owner(input string req, input int own);
        logic [3:1] ev;
        ev = (own == 0) ? 3'b000 : 3'(1 << (own - 1));
        chk(req, {29'd0, oe}, {29'd0, ev});
        chk(req, {28'd0, bus_or}, {28'd0, flag_of(own)});
        chk("R13", {31'd0, $countones(oe) <= 1}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        total++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R2: quiet outputs during reset, polled strap
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2", {26'd0, oe, syn}, 32'd0);
            chk("R2", {25'd0, t_out, bus_or}, 32'd0);
            cnt++;
        end
        rst = 1'b0;
        // Polled ring: R3 at the first edge, rotation R4/R5/R6, R1 and R11 stimulus mid-run
        for (int n = 1; n <= 30; n++) begin
            int own;
            tick();
            own = ((n - 1) % 3) + 1;
            check_owner((n == 1) ? "R3" : "R4", own);
            chk("R5", {29'd0, syn}, {29'd0, oe});
            chk("R5", {29'd0, t_out}, {29'd0, oe});
            chk("R6", {28'd0, bus_or}, {28'd0, flag_of(own)});
            cnt++;
            if (n == 9)  strap = 1'b0;          // R1
            if (n >= 12 && n <= 24) begin        // R11
                stb  = 1'b1;
                addr = 3'(n % 8);
            end else begin
                stb = 1'b0;
            end
        end
        stb = 1'b0;

        // Direct mode
        rst = 1'b1; strap = 1'b0; ring = 1'b0; busy = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        stb = 1'b1; addr = 3'd2;
        tick(); chk("R9", {29'd0, oe}, 32'd0);
        tick(); check_owner("R9", 0);
        busy = 1'b0;
        tick(); check_owner("R7", 2);
        stb = 1'b0; cnt++;
        tick(); check_owner("R7", 2);
        cnt++;
        tick(); check_owner("R7", 2);
        stb = 1'b1; addr = 3'd3;
        tick(); check_owner("R8", 3);
        busy = 1'b1; addr = 3'd1;
        tick(); check_owner("R9", 3);
        busy = 1'b0;
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a);
            cnt++;
            tick();
            check_owner("R8", (a >= 1 && a <= 3) ? a : 0);
        end
        addr = 3'd1;
        tick(); check_owner("R7", 1);
        stb = 1'b0; tforce = 3'b111;
        for (int i = 0; i < 3; i++) begin
            tick();
            check_owner("R10", 1);
            chk("R10", {26'd0, syn, t_out}, 32'd0);
            cnt++;
        end
        strap = 1'b1; tforce = '0;
        tick();
        chk("R1", {29'd0, syn}, 32'd0);
        check_owner("R1", 1);
        chk("R12", {28'd0, b2 | b3}, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule